// File: doc/BRIEF.md
# Three-wire serial register port

This block is the slave side of a three-wire serial link: a chip-enable (`ce`), a serial clock (`sclk`) and one data line, split at the block edge into `sdio_in`, `sdio_out` and the drive enable `sdio_oe`. Through it, a host reads and writes a small register set. The set holds seven timekeeping bytes, a control byte carrying a write-protect flag, a charger configuration byte and a 31-byte scratch RAM. The seven timekeeping bytes are kept by a separate counting block. This port forwards writes to that block through a strobe and reads its live time bus.

Each transfer opens with a command byte. The command selects read or write, clock or RAM space, and a register index. Index 31 in either space selects a burst that streams consecutive registers while chip-enable stays high. A clock burst read asks the counting block for a snapshot at its start, so every byte of the burst comes from one instant. The charger byte is decoded into an enable, a diode-count select and a resistor select. All `sclk` and `ce` activity is sampled with the system clock `clk`, which must run several times faster than `sclk`.

Top module: `tw_reg_port`

## Requirements
- R1: The command byte is shifted in least significant bit first. Bit 0 selects read (1) or write (0). Bits 5:1 give the index. Bit 6 selects RAM (1) or clock space (0). Bit 7 must be 1. If bit 7 is 0, the whole transfer is ignored: nothing is written and `sdio_oe` stays low.
- R2: In a single write, the data byte (LSB first) is committed on the rising `sclk` edge of its eighth bit. A clock index below 7 gives a one-cycle `tk_wr_en` with that index and the byte. A RAM index 0..30 stores the byte.
- R3: Read data goes out LSB first. The first bit is driven on the falling `sclk` edge that follows the eighth command bit. `sdio_oe` is high only in the read data phase of a valid command while `ce` is high.
- R4: Clock index 7 (write 8Eh, read 8Fh) is the control byte. Bit 7 is write-protect and bits 6:0 read 0. Write-protect is 1 after reset.
- R5: While write-protect is 1, writes to the time bytes, the charger byte and the RAM have no effect. The control byte itself stays writable.
- R6: Index 31 is a burst. In clock space it moves indices 0..7 in order. In RAM space it moves bytes 0..30 in order. Bytes clocked after the last register are ignored.
- R7: A clock burst write that begins while write-protect is 1 changes none of the eight clock-space registers, and that includes the control byte.
- R8: A clock burst read pulses `snap_req` once, at command decode. Its time bytes come from the values held at that instant, even if the live time changes during the burst. Single reads return live time.
- R9: The charger byte (index 8, write 90h, read 91h) resets to 5Ch. `chg_en` is 1 only when bits 7:4 are 1010, bits 3:2 are 01 or 10, and bits 1:0 are non-zero. When enabled, `chg_two_diodes` is bit 3 and `chg_res` is bits 1:0; when disabled, both are 0. No burst reaches this byte.
- R10: Dropping `ce` aborts any transfer. A partial command is discarded, `sdio_oe` falls, and the next transfer starts from a fresh command.
- R11: Clock indices 9..30 read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Serial chip-enable, synchronous to clk |
| sclk | input | 1 | Serial clock, synchronous to clk |
| sdio_in | input | 1 | Serial data from host |
| sdio_out | output | 1 | Serial data to host |
| sdio_oe | output | 1 | Drive enable for the data line |
| tk_time | input | 8*NUM_TIME | Live time bytes, byte i at bits 8i+7:8i |
| tk_wr_en | output | 1 | Write strobe to the counting block |
| tk_wr_idx | output | $clog2(NUM_TIME) | Time byte index written |
| tk_wr_data | output | 8 | Time byte value written |
| snap_req | output | 1 | Snapshot pulse at start of clock burst read |
| chg_en | output | 1 | Charger enabled |
| chg_two_diodes | output | 1 | 1: two diodes, 0: one diode |
| chg_res | output | 2 | Resistor select code (01, 10, 11) |

## Verification
Single reads and writes go to time, control, charger, RAM and unmapped indices. These show that the address and space fields are decoded correctly and that the bit order is right. Clock bursts and RAM bursts, including a surplus byte, separate streaming order and end-of-burst handling from single access. The same writes are repeated with write-protect set, with an invalid command bit 7 and with chip-enable dropped mid-command or mid-read. Together these show that protection, validity and abort each suppress the effect independently. A change of live time during a burst read separates snapshot data from live data. A set of charger patterns covers the legal codes and each kind of disabling code.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam logic [4:0] BURST_IDX = 5'd31;
    localparam logic [7:0] CHG_RESET = 8'h5C;
    localparam logic [3:0] CHG_KEY   = 4'b1010;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_WR,
        PH_RD,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic       valid;
        logic       ram;
        logic [4:0] idx;
        logic       rd;
    } cmd_t;

    typedef struct packed {
        logic       en;
        logic       two_diodes;
        logic [1:0] res;
    } chg_t;

    function automatic cmd_t cmd_decode(input logic [7:0] b);
        cmd_t c;
        c.rd    = b[0];
        c.idx   = b[5:1];
        c.ram   = b[6];
        c.valid = b[7];
        return c;
    endfunction

    function automatic chg_t chg_decode(input logic [7:0] r);
        chg_t c;
        c.en         = (r[7:4] == CHG_KEY) && (r[3] ^ r[2]) && (r[1:0] != 2'b00);
        c.two_diodes = c.en & r[3];
        c.res        = c.en ? r[1:0] : 2'b00;
        return c;
    endfunction

endpackage

// File: rtl/tw_edge.sv
module tw_edge (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic sclk,
    output logic rise,
    output logic fall
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk;
    end

    assign rise = ce &  sclk & ~sclk_q;
    assign fall = ce & ~sclk &  sclk_q;
endmodule

// File: rtl/tw_regs.sv
module tw_regs
    import tw_pkg::*;
#(
    parameter int NUM_TIME  = 7,
    parameter int RAM_DEPTH = 31
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic                          wr_ram,
    input  logic [4:0]                    wr_idx,
    input  logic [7:0]                    wr_data,
    input  logic                          rd_ram,
    input  logic [4:0]                    rd_idx,
    input  logic                          rd_shadow,
    input  logic                          snap,
    input  logic [8*NUM_TIME-1:0]         tk_time,
    output logic [7:0]                    rd_data,
    output logic                          wp,
    output chg_t                          chg,
    output logic                          tk_wr_en,
    output logic [$clog2(NUM_TIME)-1:0]   tk_wr_idx,
    output logic [7:0]                    tk_wr_data
);
    localparam int CTRL_IDX = NUM_TIME;
    localparam int CHG_IDX  = NUM_TIME + 1;
    localparam int IW       = $clog2(NUM_TIME);

    logic                     wp_q;
    logic [7:0]               chg_q;
    logic [8*NUM_TIME-1:0]    shadow_q;
    logic [7:0]               ram_q [RAM_DEPTH];

    assign wp         = wp_q;
    assign chg        = chg_decode(chg_q);
    assign tk_wr_en   = wr_en && !wr_ram && (int'(wr_idx) < NUM_TIME) && !wp_q;
    assign tk_wr_idx  = wr_idx[IW-1:0];
    assign tk_wr_data = wr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q     <= 1'b1;
            chg_q    <= CHG_RESET;
            shadow_q <= '0;
            for (int i = 0; i < RAM_DEPTH; i++) ram_q[i] <= 8'h00;
        end else begin
            if (snap) shadow_q <= tk_time;
            if (wr_en && !wr_ram) begin
                if (int'(wr_idx) == CTRL_IDX)           wp_q  <= wr_data[7];
                if (int'(wr_idx) == CHG_IDX && !wp_q)   chg_q <= wr_data;
            end
            if (wr_en && wr_ram && !wp_q && int'(wr_idx) < RAM_DEPTH)
                ram_q[wr_idx] <= wr_data;
        end
    end

    always_comb begin
        rd_data = 8'h00;
        if (rd_ram) begin
            if (int'(rd_idx) < RAM_DEPTH) rd_data = ram_q[rd_idx];
        end else if (int'(rd_idx) < NUM_TIME) begin
            rd_data = rd_shadow ? shadow_q[int'(rd_idx)*8 +: 8]
                                : tk_time[int'(rd_idx)*8 +: 8];
        end else if (int'(rd_idx) == CTRL_IDX) begin
            rd_data = {wp_q, 7'b0};
        end else if (int'(rd_idx) == CHG_IDX) begin
            rd_data = chg_q;
        end
    end
endmodule

// File: rtl/tw_reg_port.sv
module tw_reg_port
    import tw_pkg::*;
#(
    parameter int NUM_TIME  = 7,
    parameter int RAM_DEPTH = 31
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          ce,
    input  logic                          sclk,
    input  logic                          sdio_in,
    output logic                          sdio_out,
    output logic                          sdio_oe,
    input  logic [8*NUM_TIME-1:0]         tk_time,
    output logic                          tk_wr_en,
    output logic [$clog2(NUM_TIME)-1:0]   tk_wr_idx,
    output logic [7:0]                    tk_wr_data,
    output logic                          snap_req,
    output logic                          chg_en,
    output logic                          chg_two_diodes,
    output logic [1:0]                    chg_res
);
    localparam logic [4:0] CLK_LAST = 5'(NUM_TIME);
    localparam logic [4:0] RAM_LAST = 5'(RAM_DEPTH - 1);

    logic       rise, fall;
    phase_e     phase_q;
    logic [2:0] bit_q;
    logic [7:0] sh_q;
    logic [4:0] idx_q;
    logic       ram_q, burst_q, drop_q, oe_q, out_q;
    logic [7:0] nb_w, rd_data_w;
    cmd_t       cmd_w;
    logic       byte_done, at_last, wr_en_w, wp_w;
    chg_t       chg_w;

    tw_edge u_edge (
        .clk (clk), .rst (rst), .ce (ce), .sclk (sclk),
        .rise(rise), .fall(fall)
    );

    assign nb_w      = {sdio_in, sh_q[7:1]};
    assign cmd_w     = cmd_decode(nb_w);
    assign byte_done = rise && (bit_q == 3'd7);
    assign at_last   = idx_q == (ram_q ? RAM_LAST : CLK_LAST);
    assign wr_en_w   = byte_done && (phase_q == PH_WR) && !drop_q;
    assign snap_req  = byte_done && (phase_q == PH_CMD) && cmd_w.valid && cmd_w.rd
                       && !cmd_w.ram && (cmd_w.idx == BURST_IDX);

    always_ff @(posedge clk) begin
        if (rst || !ce) begin
            phase_q <= PH_CMD;
            bit_q   <= 3'd0;
            sh_q    <= 8'h00;
            idx_q   <= 5'd0;
            ram_q   <= 1'b0;
            burst_q <= 1'b0;
            drop_q  <= 1'b0;
            oe_q    <= 1'b0;
            out_q   <= 1'b0;
        end else begin
            if (rise && phase_q != PH_SKIP) begin
                bit_q <= bit_q + 3'd1;
                sh_q  <= nb_w;
            end
            if (byte_done) begin
                unique case (phase_q)
                    PH_CMD: begin
                        if (!cmd_w.valid) begin
                            phase_q <= PH_SKIP;
                        end else begin
                            phase_q <= cmd_w.rd ? PH_RD : PH_WR;
                            ram_q   <= cmd_w.ram;
                            burst_q <= cmd_w.idx == BURST_IDX;
                            idx_q   <= (cmd_w.idx == BURST_IDX) ? 5'd0 : cmd_w.idx;
                            drop_q  <= (cmd_w.idx == BURST_IDX) && !cmd_w.ram
                                       && !cmd_w.rd && wp_w;
                        end
                    end
                    PH_WR, PH_RD: begin
                        if (burst_q) begin
                            if (at_last) begin
                                phase_q <= PH_SKIP;
                                oe_q    <= 1'b0;
                            end else begin
                                idx_q <= idx_q + 5'd1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
            if (fall && phase_q == PH_RD) begin
                out_q <= rd_data_w[bit_q];
                oe_q  <= 1'b1;
            end
        end
    end

    tw_regs #(.NUM_TIME(NUM_TIME), .RAM_DEPTH(RAM_DEPTH)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en_w),
        .wr_ram    (ram_q),
        .wr_idx    (idx_q),
        .wr_data   (nb_w),
        .rd_ram    (ram_q),
        .rd_idx    (idx_q),
        .rd_shadow (burst_q && !ram_q),
        .snap      (snap_req),
        .tk_time   (tk_time),
        .rd_data   (rd_data_w),
        .wp        (wp_w),
        .chg       (chg_w),
        .tk_wr_en  (tk_wr_en),
        .tk_wr_idx (tk_wr_idx),
        .tk_wr_data(tk_wr_data)
    );

    assign sdio_out       = out_q;
    assign sdio_oe        = oe_q;
    assign chg_en         = chg_w.en;
    assign chg_two_diodes = chg_w.two_diodes;
    assign chg_res        = chg_w.res;
endmodule

// File: rtl/tw_reg_port_chk.sv
module tw_reg_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       ce,
    input logic       sdio_oe,
    input logic       snap_req,
    input logic       tk_wr_en,
    input logic       wp,
    input logic       chg_en,
    input logic       chg_two_diodes,
    input logic [1:0] chg_res
);
    p_oe_released_r3: assert property (@(posedge clk) disable iff (rst)
        !ce |=> !sdio_oe);

    p_write_needs_ce_r2: assert property (@(posedge clk) disable iff (rst)
        tk_wr_en |-> ce);

    p_protect_blocks_r5: assert property (@(posedge clk) disable iff (rst)
        wp |-> !tk_wr_en);

    p_snap_one_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        snap_req |=> !snap_req);

    p_charger_legal_r9: assert property (@(posedge clk) disable iff (rst)
        chg_en |-> (chg_res != 2'b00));

    p_abort_holds_charger_r10: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable({chg_en, chg_two_diodes, chg_res}));
endmodule

bind tw_reg_port tw_reg_port_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .ce            (ce),
    .sdio_oe       (sdio_oe),
    .snap_req      (snap_req),
    .tk_wr_en      (tk_wr_en),
    .wp            (wp_w),
    .chg_en        (chg_en),
    .chg_two_diodes(chg_two_diodes),
    .chg_res       (chg_res)
);

// File: tb/sim_tw_reg_port.sv
module sim_tw_reg_port;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce = 1'b0, sclk = 1'b0, sdio_in = 1'b0;
    logic sdio_out, sdio_oe, tk_wr_en, snap_req, chg_en, chg_two_diodes;
    logic [2:0] tk_wr_idx;
    logic [7:0] tk_wr_data;
    logic [1:0] chg_res;
    logic [8*NT-1:0] tk_time;

    logic [7:0] tk [NT];
    logic       poke = 1'b0;
    logic [7:0] poke_val = 8'h00;
    int tk_wr_cnt = 0, snap_cnt = 0;
    int checks = 0, fails = 0;
    bit done = 0;
    logic oe_seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    tw_reg_port u0 (
        .clk(clk), .rst(rst), .ce(ce), .sclk(sclk), .sdio_in(sdio_in),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .tk_time(tk_time),
        .tk_wr_en(tk_wr_en), .tk_wr_idx(tk_wr_idx), .tk_wr_data(tk_wr_data),
        .snap_req(snap_req), .chg_en(chg_en), .chg_two_diodes(chg_two_diodes),
        .chg_res(chg_res)
    );

    // bench model of the counting block
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NT; i++) tk[i] <= 8'h00;
        end else if (tk_wr_en) begin
            tk[tk_wr_idx] <= tk_wr_data;
            tk_wr_cnt <= tk_wr_cnt + 1;
        end else if (poke) begin
            tk[1] <= poke_val;
        end
        if (snap_req) snap_cnt <= snap_cnt + 1;
    end

    always_comb for (int i = 0; i < NT; i++) tk_time[i*8 +: 8] = tk[i];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic sc_low();
        @(negedge clk) sclk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic sc_high();
        @(negedge clk) sclk = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic xfer_begin();
        @(negedge clk) ce = 1'b1;
        oe_seen = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic xfer_end();
        sc_low();
        ce = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic put_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            sc_low();
            sdio_in = b[i];
            sc_high();
        end
    endtask

    task automatic get_byte(output logic [7:0] d);
        for (int i = 0; i < 8; i++) begin
            sc_low();
            d[i] = sdio_out;
            oe_seen |= sdio_oe;
            sc_high();
        end
    endtask

    task automatic wr1(input logic [7:0] cmd, input logic [7:0] d);
        xfer_begin();
        put_bits(cmd, 8);
        put_bits(d, 8);
        xfer_end();
    endtask

    task automatic rd1(input logic [7:0] cmd, output logic [7:0] d);
        xfer_begin();
        put_bits(cmd, 8);
        get_byte(d);
        xfer_end();
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk(sdio_oe == 1'b0, "R3 oe idle", sdio_oe, 0);
        chk(chg_en == 1'b0, "R9 reset chg_en", chg_en, 0);
        rd1(8'h91, d);
        chk(d == 8'h5C, "R9 charger reset value", d, 8'h5C);
        rd1(8'h8F, d);
        chk(d == 8'h80, "R4 control reset value", d, 8'h80);
    endtask

    task automatic t_protect();
        logic [7:0] d;
        wr1(8'hC4, 8'h11);
        wr1(8'h80, 8'h22);
        chk(tk_wr_cnt == 0, "R5 time write blocked", tk_wr_cnt, 0);
        rd1(8'hC5, d);
        chk(d == 8'h00, "R5 RAM write blocked", d, 0);
        wr1(8'h90, 8'hA5);
        chk(chg_en == 1'b0, "R5 charger write blocked", chg_en, 0);
        wr1(8'h8E, 8'h7F);
        rd1(8'h8F, d);
        chk(d == 8'h00, "R4 control clear, low bits read 0", d, 0);
    endtask

    task automatic t_single();
        logic [7:0] d;
        wr1(8'h82, 8'h45);
        chk(tk[1] == 8'h45 && tk_wr_cnt == 1, "R2 time write strobe", tk[1], 8'h45);
        rd1(8'h83, d);
        chk(d == 8'h45, "R2 time read", d, 8'h45);
        wr1(8'hC4, 8'hA5);
        xfer_begin();
        put_bits(8'hC5, 8);
        chk(sdio_oe == 1'b0, "R3 oe low during command", sdio_oe, 0);
        sc_low();
        chk(sdio_out == 1'b1 && sdio_oe == 1'b1, "R3 first bit on falling edge", {sdio_oe, sdio_out}, 3);
        sc_high();
        d[0] = 1'b1;
        for (int i = 1; i < 8; i++) begin
            sc_low();
            d[i] = sdio_out;
            sc_high();
        end
        xfer_end();
        chk(d == 8'hA5, "R2 R3 RAM read LSB first", d, 8'hA5);
    endtask

    task automatic t_bad_cmd();
        logic [7:0] d;
        wr1(8'h44, 8'h77);
        rd1(8'hC5, d);
        chk(d == 8'hA5, "R1 bit7 zero write ignored", d, 8'hA5);
        rd1(8'h45, d);
        chk(oe_seen == 1'b0, "R1 bit7 zero read not driven", oe_seen, 0);
    endtask

    task automatic t_clock_burst();
        logic [7:0] d;
        xfer_begin();
        put_bits(8'hBE, 8);
        for (int i = 0; i < 7; i++) put_bits(8'h10 + 8'(i), 8);
        put_bits(8'h00, 8);
        xfer_end();
        for (int i = 0; i < 7; i++)
            chk(tk[i] == 8'h10 + 8'(i), "R6 clock burst write", tk[i], 8'h10 + i);
        xfer_begin();
        put_bits(8'hBF, 8);
        for (int i = 0; i < 8; i++) begin
            get_byte(d);
            chk(d == ((i < 7) ? 8'h10 + 8'(i) : 8'h00), "R6 clock burst read", d, (i < 7) ? 8'h10 + i : 0);
        end
        xfer_end();
    endtask

    task automatic t_ram_burst();
        logic [7:0] d;
        xfer_begin();
        put_bits(8'hFE, 8);
        for (int i = 0; i < 31; i++) put_bits(8'(i*7+3), 8);
        put_bits(8'hEE, 8);
        xfer_end();
        xfer_begin();
        put_bits(8'hFF, 8);
        for (int i = 0; i < 31; i++) begin
            get_byte(d);
            chk(d == 8'(i*7+3), "R6 RAM burst", d, 8'(i*7+3));
        end
        xfer_end();
        rd1(8'hC1, d);
        chk(d == 8'h03, "R6 surplus burst byte ignored", d, 3);
    endtask

    task automatic t_snapshot();
        logic [7:0] d;
        int s0;
        s0 = snap_cnt;
        xfer_begin();
        put_bits(8'hBF, 8);
        get_byte(d);
        @(negedge clk) begin poke = 1'b1; poke_val = 8'h99; end
        @(negedge clk) poke = 1'b0;
        get_byte(d);
        chk(d == 8'h11, "R8 burst byte from snapshot", d, 8'h11);
        xfer_end();
        chk(snap_cnt == s0 + 1, "R8 one snapshot pulse", snap_cnt - s0, 1);
        rd1(8'h83, d);
        chk(d == 8'h99, "R8 single read is live", d, 8'h99);
    endtask

    task automatic t_burst_protect();
        logic [7:0] d;
        logic [7:0] old [NT];
        for (int i = 0; i < NT; i++) old[i] = tk[i];
        wr1(8'h8E, 8'h80);
        xfer_begin();
        put_bits(8'hBE, 8);
        for (int i = 0; i < 8; i++) put_bits(8'h00, 8);
        xfer_end();
        for (int i = 0; i < NT; i++)
            chk(tk[i] == old[i], "R7 protected burst drops time", tk[i], old[i]);
        rd1(8'h8F, d);
        chk(d == 8'h80, "R7 protected burst keeps control", d, 8'h80);
        wr1(8'h8E, 8'h00);
    endtask

    task automatic t_charger();
        logic [7:0] pat [6] = '{8'hA5, 8'hA9, 8'hAB, 8'hAC, 8'hA4, 8'h5C};
        logic [3:0] exp [6] = '{4'b1001, 4'b1101, 4'b1111, 4'b0000, 4'b0000, 4'b0000};
        logic [7:0] d;
        for (int i = 0; i < 6; i++) begin
            wr1(8'h90, pat[i]);
            chk({chg_en, chg_two_diodes, chg_res} == exp[i], "R9 charger decode",
                {chg_en, chg_two_diodes, chg_res}, exp[i]);
        end
        wr1(8'h90, 8'hA6);
        xfer_begin();
        put_bits(8'hBE, 8);
        for (int i = 0; i < 9; i++) put_bits(8'h00, 8);
        xfer_end();
        rd1(8'h91, d);
        chk(d == 8'hA6 && chg_en, "R9 burst cannot reach charger", d, 8'hA6);
    endtask

    task automatic t_abort();
        logic [7:0] d;
        xfer_begin();
        put_bits(8'hC4, 4);
        xfer_end();
        wr1(8'hC4, 8'h3C);
        rd1(8'hC5, d);
        chk(d == 8'h3C, "R10 partial command discarded", d, 8'h3C);
        xfer_begin();
        put_bits(8'hC5, 8);
        for (int i = 0; i < 3; i++) begin sc_low(); sc_high(); end
        sc_low();
        chk(sdio_oe == 1'b1, "R10 driving before abort", sdio_oe, 1);
        @(negedge clk) ce = 1'b0;
        repeat (2) @(negedge clk);
        chk(sdio_oe == 1'b0, "R10 abort releases line", sdio_oe, 0);
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        int c0;
        c0 = tk_wr_cnt;
        wr1(8'h94, 8'h33);
        rd1(8'h95, d);
        chk(d == 8'h00 && tk_wr_cnt == c0, "R11 unmapped index", d, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_protect();
        t_single();
        t_bad_cmd();
        t_clock_burst();
        t_ram_burst();
        t_snapshot();
        t_burst_protect();
        t_charger();
        t_abort();
        t_unmapped();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule